// File: doc/BRIEF.md
# Debounced Per-Line GPIO Interrupt Combiner

This block sits between a bank of general-purpose input lines and an upstream interrupt controller. Each line is first brought into the local clock domain by a two-stage synchroniser. A debouncer then filters it: the line must hold a new value for a programmable number of slow sample ticks before the change is accepted. After that, a condition stage qualifies the line. Software picks, for each line on its own, level or edge sensitivity and the active sense. The qualified lines are merged into a single registered interrupt output.

Software programs the block through a simple register port made of a valid strobe, a write flag, an 8-bit byte offset and 32-bit write data. Read data is registered. Status can be read either before or after masking. Latched edge events are cleared by writing ones to a write-only clear register. A debounce length of zero bypasses the filter. With that setting, a single enabled, unmasked, active-high level line turns the block into a plain delayed wire from that input to the interrupt output.

Top module: `gpio_irq_frontend`

## Requirements
- R1: After reset the enable, mask, type, polarity and debounce-length registers all read 0 (every line level sensitive and active low, filter bypassed), both status views read 0, and `irq_o` is 0.
- R2: Registers at offsets 0x30 (enable), 0x34 (mask), 0x38 (type, 1 = edge, 0 = level) and 0x3C (polarity, 1 = active high or rising, 0 = active low or falling) read back the written value, one bit per line with line n at bit n. Offset 0x48 holds the debounce length in its low CNT_W bits, and its upper bits read 0.
- R3: With only line 12 enabled, unmasked, level type, active high and debounce length 0, `irq_o` follows `gpio_in[12]` exactly three clock edges later.
- R4: For an enabled level line, status bit n is 1 exactly while the debounced input equals the polarity bit, so an active-low line reports 1 while its input is 0.
- R5: For an enabled edge line, status bit n is set by a transition of the debounced input toward the polarity value. The bit stays set after the input returns.
- R6: Writing offset 0x4C clears the latched edge status of every line whose written bit is 1, leaves the others untouched, and reads back 0.
- R7: A set mask bit removes the line from the masked status view (offset 0x40) and from `irq_o`, while the raw status view (offset 0x44) still shows it.
- R8: A line whose enable bit is 0 never shows status, whatever its input does.
- R9: `irq_o` is the OR of the masked status bits, registered one clock later.
- R10: With a nonzero debounce length L, the debounced state changes only on a sample tick, once the synchronised input has differed from it on L consecutive ticks. A pulse that spans fewer ticks is ignored.
- R11: Reads of unmapped offsets return 0. Writes to the two status offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | N_LINES | Asynchronous general-purpose input lines |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid on the clock after a read strobe |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong edge latch shows up as a status bit that survives a clear, or that never appears, at the next status read. On an unmasked line it also shows on `irq_o` one clock after the faulty cycle. A wrong polarity or type decode inverts or freezes a line's status within the three-edge input latency, so each combination of line, type and polarity is swept and checked at fixed cycle offsets. Debouncer miscounts move the point of acceptance by whole sample periods, so the filter is probed both before and after the earliest legal acceptance time and with a pulse that is too short.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 32;

    // Register byte offsets
    localparam logic [BUS_AW-1:0] OFS_ENABLE = 8'h30;
    localparam logic [BUS_AW-1:0] OFS_MASK   = 8'h34;
    localparam logic [BUS_AW-1:0] OFS_TYPE   = 8'h38;
    localparam logic [BUS_AW-1:0] OFS_POL    = 8'h3C;
    localparam logic [BUS_AW-1:0] OFS_MSTAT  = 8'h40;
    localparam logic [BUS_AW-1:0] OFS_RSTAT  = 8'h44;
    localparam logic [BUS_AW-1:0] OFS_DBLEN  = 8'h48;
    localparam logic [BUS_AW-1:0] OFS_EOI    = 8'h4C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_MASK,
        SEL_TYPE,
        SEL_POL,
        SEL_MSTAT,
        SEL_RSTAT,
        SEL_DBLEN,
        SEL_EOI
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        reg_sel_e          sel;
        logic [BUS_DW-1:0] data;
    } reg_req_t;

    function automatic reg_sel_e decode_sel(input logic [BUS_AW-1:0] addr);
        case (addr)
            OFS_ENABLE: return SEL_ENABLE;
            OFS_MASK:   return SEL_MASK;
            OFS_TYPE:   return SEL_TYPE;
            OFS_POL:    return SEL_POL;
            OFS_MSTAT:  return SEL_MSTAT;
            OFS_RSTAT:  return SEL_RSTAT;
            OFS_DBLEN:  return SEL_DBLEN;
            OFS_EOI:    return SEL_EOI;
            default:    return SEL_NONE;
        endcase
    endfunction

    // Active-sense qualification of one debounced line
    function automatic logic qualify(input logic level, input logic active_high);
        return active_high ? level : ~level;
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned CNT_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  reg_req_t            req,
    input  logic [N_LINES-1:0]  raw_stat,
    input  logic [N_LINES-1:0]  masked_stat,
    output logic [N_LINES-1:0]  en_q,
    output logic [N_LINES-1:0]  mask_q,
    output logic [N_LINES-1:0]  type_q,
    output logic [N_LINES-1:0]  pol_q,
    output logic [CNT_W-1:0]    db_len_q,
    output logic [N_LINES-1:0]  eoi_vec,
    output logic [BUS_DW-1:0]   rdata
);

    logic wr_hit;
    logic rd_hit;

    assign wr_hit = req.valid &&  req.write;
    assign rd_hit = req.valid && !req.write;

    // Control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            mask_q   <= '0;
            type_q   <= '0;
            pol_q    <= '0;
            db_len_q <= '0;
        end else if (wr_hit) begin
            case (req.sel)
                SEL_ENABLE: en_q     <= req.data[N_LINES-1:0];
                SEL_MASK:   mask_q   <= req.data[N_LINES-1:0];
                SEL_TYPE:   type_q   <= req.data[N_LINES-1:0];
                SEL_POL:    pol_q    <= req.data[N_LINES-1:0];
                SEL_DBLEN:  db_len_q <= req.data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Edge clear pulse: one cycle, only on a write to the clear offset
    assign eoi_vec = (wr_hit && req.sel == SEL_EOI) ? req.data[N_LINES-1:0] : '0;

    // Registered read mux
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_hit) begin
            case (req.sel)
                SEL_ENABLE: rdata <= BUS_DW'(en_q);
                SEL_MASK:   rdata <= BUS_DW'(mask_q);
                SEL_TYPE:   rdata <= BUS_DW'(type_q);
                SEL_POL:    rdata <= BUS_DW'(pol_q);
                SEL_MSTAT:  rdata <= BUS_DW'(masked_stat);
                SEL_RSTAT:  rdata <= BUS_DW'(raw_stat);
                SEL_DBLEN:  rdata <= BUS_DW'(db_len_q);
                default:    rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_debounce.sv
`timescale 1ns/1ps
module gpio_irq_debounce #(
    parameter int unsigned N_LINES    = 32,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned SAMPLE_DIV = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_LINES-1:0]  pin_i,
    input  logic [CNT_W-1:0]    len_i,
    output logic                tick_o,
    output logic [N_LINES-1:0]  state_o,
    output logic [N_LINES-1:0]  deb_o
);

    localparam int unsigned DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

    logic [N_LINES-1:0] sync1_q;
    logic [N_LINES-1:0] sync2_q;
    logic [DIV_W-1:0]   div_q;
    logic               tick_q;
    logic               bypass;

    // Two-flop synchroniser
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
        end
    end

    // Slow sample tick generator
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            tick_q <= 1'b0;
        end else if (div_q == DIV_LAST) begin
            div_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;
    assign bypass = (len_i == '0);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic [CNT_W-1:0] run_q;
        logic             st_q;
        logic             reached;

        assign reached = ({1'b0, run_q} + 1'b1) >= {1'b0, len_i};

        always_ff @(posedge clk) begin
            if (rst) begin
                run_q <= '0;
                st_q  <= 1'b0;
            end else if (bypass) begin
                run_q <= '0;
                st_q  <= sync2_q[i];
            end else if (tick_q) begin
                if (sync2_q[i] == st_q) begin
                    run_q <= '0;
                end else if (reached) begin
                    run_q <= '0;
                    st_q  <= sync2_q[i];
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end

        assign state_o[i] = st_q;
        assign deb_o[i]   = bypass ? sync2_q[i] : st_q;
    end

endmodule

// File: rtl/gpio_irq_cond.sv
`timescale 1ns/1ps
module gpio_irq_cond
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_LINES = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_LINES-1:0]  deb_i,
    input  logic [N_LINES-1:0]  en_i,
    input  logic [N_LINES-1:0]  mask_i,
    input  logic [N_LINES-1:0]  type_i,
    input  logic [N_LINES-1:0]  pol_i,
    input  logic [N_LINES-1:0]  eoi_i,
    output logic [N_LINES-1:0]  raw_o,
    output logic [N_LINES-1:0]  masked_o
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic active;
        logic prev_q;
        logic hit_q;
        logic rise;

        assign active = qualify(deb_i[i], pol_i[i]);
        assign rise   = active & ~prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                hit_q  <= 1'b0;
            end else begin
                prev_q <= active;
                if (!en_i[i])
                    hit_q <= 1'b0;
                else if (rise)
                    hit_q <= 1'b1;
                else if (eoi_i[i])
                    hit_q <= 1'b0;
            end
        end

        assign raw_o[i] = en_i[i] & (type_i[i] ? hit_q : active);
    end

    assign masked_o = raw_o & ~mask_i;

endmodule

// File: rtl/gpio_irq_frontend.sv
`timescale 1ns/1ps
module gpio_irq_frontend
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_LINES    = 32,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned SAMPLE_DIV = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_LINES-1:0]  gpio_in,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq_o
);

    reg_req_t           req;
    logic [N_LINES-1:0] en_q, mask_q, type_q, pol_q, eoi_vec;
    logic [CNT_W-1:0]   db_len_q;
    logic [N_LINES-1:0] deb, deb_state;
    logic [N_LINES-1:0] raw_stat, masked_stat;
    logic               tick;
    logic               irq_q;

    assign req.valid = bus_valid;
    assign req.write = bus_write;
    assign req.sel   = decode_sel(bus_addr);
    assign req.data  = bus_wdata;

    gpio_irq_regs #(.N_LINES(N_LINES), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .raw_stat    (raw_stat),
        .masked_stat (masked_stat),
        .en_q        (en_q),
        .mask_q      (mask_q),
        .type_q      (type_q),
        .pol_q       (pol_q),
        .db_len_q    (db_len_q),
        .eoi_vec     (eoi_vec),
        .rdata       (bus_rdata)
    );

    gpio_irq_debounce #(.N_LINES(N_LINES), .CNT_W(CNT_W), .SAMPLE_DIV(SAMPLE_DIV)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (gpio_in),
        .len_i   (db_len_q),
        .tick_o  (tick),
        .state_o (deb_state),
        .deb_o   (deb)
    );

    gpio_irq_cond #(.N_LINES(N_LINES)) u_cond (
        .clk      (clk),
        .rst      (rst),
        .deb_i    (deb),
        .en_i     (en_q),
        .mask_i   (mask_q),
        .type_i   (type_q),
        .pol_i    (pol_q),
        .eoi_i    (eoi_vec),
        .raw_o    (raw_stat),
        .masked_o (masked_stat)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked_stat;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/gpio_irq_frontend_chk.sv
`timescale 1ns/1ps
module gpio_irq_frontend_chk #(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned CNT_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_o,
    input logic [N_LINES-1:0] raw_stat,
    input logic [N_LINES-1:0] masked_stat,
    input logic [N_LINES-1:0] en_q,
    input logic [N_LINES-1:0] mask_q,
    input logic [CNT_W-1:0]   db_len_q,
    input logic               tick,
    input logic [N_LINES-1:0] deb_state
);

    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    // R1
    always @(negedge clk) begin
        if (rst_seen_q) begin
            reset_quiet_chk: assert (!irq_o && en_q == '0 && raw_stat == '0);
        end
    end

    // R9
    irq_follows_masked_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|masked_stat)));

    // R7
    mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (masked_stat & mask_q) == '0);

    // R7
    masked_within_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (masked_stat & ~raw_stat) == '0);

    // R8
    disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_stat & ~en_q) == '0);

    // R10
    deb_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (db_len_q != '0 && !tick) |=> $stable(deb_state));

endmodule

bind gpio_irq_frontend gpio_irq_frontend_chk #(.N_LINES(N_LINES), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_o       (irq_o),
    .raw_stat    (raw_stat),
    .masked_stat (masked_stat),
    .en_q        (en_q),
    .mask_q      (mask_q),
    .db_len_q    (db_len_q),
    .tick        (tick),
    .deb_state   (deb_state)
);

// File: tb/tb_gpio_irq_frontend.sv
`timescale 1ns/1ps
module tb_gpio_irq_frontend;

    localparam int unsigned N = 32;
    localparam logic [7:0] A_EN = 8'h30, A_MASK = 8'h34, A_TYPE = 8'h38, A_POL = 8'h3C;
    localparam logic [7:0] A_MST = 8'h40, A_RST = 8'h44, A_DB = 8'h48, A_EOI = 8'h4C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] gpio_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_frontend dut (
        .clk       (clk),
        .rst       (rst),
        .gpio_in   (gpio_in),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #1200000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int lines[4] = '{0, 5, 12, 31};

        idle(4);
        rst = 1'b0;

        // R1 reset values
        chk("R1 irq", 32'(irq_o), 0);
        rd(A_EN, d);   chk("R1 enable", d, 0);
        rd(A_MASK, d); chk("R1 mask", d, 0);
        rd(A_TYPE, d); chk("R1 type", d, 0);
        rd(A_POL, d);  chk("R1 pol", d, 0);
        rd(A_DB, d);   chk("R1 dblen", d, 0);
        rd(A_RST, d);  chk("R1 raw", d, 0);
        rd(A_MST, d);  chk("R1 masked", d, 0);

        // R2 readback
        wr(A_MASK, 32'hA5A5_0F0F); rd(A_MASK, d); chk("R2 mask", d, 32'hA5A5_0F0F);
        wr(A_TYPE, 32'h1234_5678); rd(A_TYPE, d); chk("R2 type", d, 32'h1234_5678);
        wr(A_POL,  32'hFEDC_BA98); rd(A_POL, d);  chk("R2 pol", d, 32'hFEDC_BA98);
        wr(A_DB,   32'h0000_01AB); rd(A_DB, d);   chk("R2 dblen", d, 32'h0000_00AB);
        wr(A_DB, 0); wr(A_MASK, 0); wr(A_TYPE, 0); wr(A_POL, 0);
        wr(A_EN,   32'h8000_0001); rd(A_EN, d);   chk("R2 enable", d, 32'h8000_0001);
        wr(A_EN, 0);

        // R4 R5 R6 sweep: lines x type x polarity
        foreach (lines[k]) begin
            for (int typ = 0; typ < 2; typ++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    int ln = lines[k];
                    logic [31:0] bit_v = 32'h1 << ln;
                    wr(A_EN, 0);
                    gpio_in = '0;
                    gpio_in[ln] = (pol == 0);
                    wr(A_TYPE, typ ? bit_v : 0);
                    wr(A_POL, pol ? bit_v : 0);
                    idle(4);
                    wr(A_EN, bit_v);
                    wr(A_EOI, 32'hFFFF_FFFF);
                    idle(2);
                    rd(A_RST, d); chk(typ ? "R5 idle raw" : "R4 idle raw", d, 0);
                    chk("R9 idle irq", 32'(irq_o), 0);
                    gpio_in[ln] = (pol == 1);
                    idle(4);
                    rd(A_RST, d); chk(typ ? "R5 active raw" : "R4 active raw", d, bit_v);
                    rd(A_MST, d); chk("R7 masked unmasked line", d, bit_v);
                    chk("R9 active irq", 32'(irq_o), 1);
                    gpio_in[ln] = (pol == 0);
                    idle(4);
                    rd(A_RST, d); chk(typ ? "R5 held after release" : "R4 released", d, typ ? bit_v : 0);
                    wr(A_EOI, bit_v);
                    idle(1);
                    rd(A_RST, d); chk("R6 cleared", d, 0);
                end
            end
        end

        // R6 selective clear
        wr(A_EN, 0); gpio_in = '0;
        wr(A_TYPE, 32'h0000_0204); wr(A_POL, 32'h0000_0204);
        wr(A_EN, 32'h0000_0204); wr(A_EOI, 32'hFFFF_FFFF);
        gpio_in = 32'h0000_0204; idle(4);
        rd(A_RST, d); chk("R6 both latched", d, 32'h0000_0204);
        wr(A_EOI, 32'h0000_0004); idle(1);
        rd(A_RST, d); chk("R6 only bit2 cleared", d, 32'h0000_0200);
        rd(A_EOI, d); chk("R6 clear reads zero", d, 0);

        // R3 pass-through on line 12
        wr(A_EN, 0); gpio_in = '0;
        wr(A_TYPE, 0); wr(A_POL, 32'h0000_1000); wr(A_MASK, 0); wr(A_DB, 0);
        wr(A_EN, 32'h0000_1000); idle(4);
        chk("R3 low", 32'(irq_o), 0);
        gpio_in[12] = 1'b1;
        idle(2); chk("R3 not yet after two edges", 32'(irq_o), 0);
        idle(1); chk("R3 high after three edges", 32'(irq_o), 1);
        gpio_in[12] = 1'b0;
        idle(2); chk("R3 still high", 32'(irq_o), 1);
        idle(1); chk("R3 low after three edges", 32'(irq_o), 0);

        // R7 mask keeps raw status
        gpio_in[12] = 1'b1; idle(4);
        wr(A_MASK, 32'h0000_1000); idle(2);
        rd(A_MST, d); chk("R7 masked view", d, 0);
        rd(A_RST, d); chk("R7 raw view", d, 32'h0000_1000);
        chk("R7 irq blocked", 32'(irq_o), 0);
        wr(A_MASK, 0); idle(2);
        chk("R7 irq after unmask", 32'(irq_o), 1);

        // R8 disabled lines silent
        wr(A_POL, 32'hFFFF_FFFF); wr(A_EN, 32'h0000_0010);
        gpio_in = 32'hFFFF_FFFF; idle(4);
        rd(A_RST, d); chk("R8 only enabled line", d, 32'h0000_0010);

        // R11 unmapped and read-only offsets
        rd(8'h50, d); chk("R11 unmapped read", d, 0);
        wr(A_RST, 32'h0F0F_0F0F); wr(A_MST, 32'h0F0F_0F0F);
        rd(A_RST, d); chk("R11 raw write ignored", d, 32'h0000_0010);
        rd(A_EN, d);  chk("R11 enable untouched", d, 32'h0000_0010);

        // R10 debounce, length 3 ticks, tick every 4 clocks
        wr(A_EN, 0); gpio_in = '0;
        wr(A_TYPE, 0); wr(A_POL, 32'h0000_0008); wr(A_DB, 3);
        idle(20);
        wr(A_EN, 32'h0000_0008); idle(2);
        rd(A_RST, d); chk("R10 quiet start", d, 0);
        gpio_in[3] = 1'b1; idle(4); gpio_in[3] = 1'b0;
        idle(20);
        rd(A_RST, d); chk("R10 short pulse ignored", d, 0);
        gpio_in[3] = 1'b1;
        rd(A_RST, d); chk("R10 not accepted early", d, 0);
        idle(40);
        rd(A_RST, d); chk("R10 stable change accepted", d, 32'h0000_0008);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule